// File: doc/BRIEF.md
# Minimal Single-Cycle Counting Processor

This block is a very small processor core that runs a fixed built-in program. It handles three instructions from the 32-bit RISC-V base set: add-immediate, branch-if-not-equal and an optional word load. It completes exactly one instruction on every rising clock edge. The program counter and the register file write port are the only clocked state. Instruction fetch, decode, immediate generation, the ALU and the data memory read all settle combinationally within the cycle.

The program lives in a read-only instruction store that is computed at elaboration. It counts register a0 from 0 up to a parameterised limit. It then loads two consecutive words from a separate data store into a0, moves the load pointer on by one word, and starts the count again. The data store holds one ramp period of samples, defined by a base and a step.

The core's only data output is a0, taken straight from the register file. A system observes the core only through the values a0 takes.

Top module: `mini_core`

## Requirements
- R1: Each rising clock edge with rst low executes one instruction. For every instruction other than a taken branch, the next PC is PC+4.
- R2: add-immediate (opcode 0010011, funct3 000) writes rs1 plus the sign-extended 12-bit immediate taken from bits 31:20 into rd. The new value appears on a0Out right after the edge that executes it.
- R3: branch-if-not-equal (opcode 1100011, funct3 001) compares rs1 and rs2. When they differ, the next PC is PC plus the B-type offset {ins[31], ins[7], ins[30:25], ins[11:8], 0}, sign-extended. When they are equal, the next PC is PC+4.
- R4: The word load (opcode 0000011, funct3 010) writes data word ((rs1+imm)>>2) mod DMEM_WORDS into rd. Data word i holds SAMPLE_BASE + i*SAMPLE_STEP.
- R5: Writes to register x0 are dropped, and x0 always reads as zero.
- R6: Any other opcode/funct3 combination is a no-op. No register is written and the PC advances by 4.
- R7: While rst is high, each rising edge sets the PC to 0 and clears every register, so a0Out reads 0.
- R8: a0Out always shows register x10. It changes only on an edge that writes x10.
- R9: The program runs in this order: it sets the limit in x1, writes to x0, executes an unsupported word and sets a0 to 0. It then increments a0 until a0 equals LOOP_LIMIT, loads data words p and p+1 into a0 and takes an always-true branch back to the clear. Pass p starts at 0 after reset and rises by 1 on each pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a0Out | output | 32 | Current contents of register x10 (a0) |

## Verification
The checker verifies on every cycle that the PC sequencing is correct: it steps by 4 unless a branch is taken, lands on PC plus the offset when one is, and stays word-aligned. It also checks that unsupported encodings raise no write or branch strobe, that a0 holds steady across cycles that do not write x10, and that reset returns the PC and a0 to zero.

The arithmetic itself needs the bench's scenarios. These cover the add and load results, the dropped x0 write seen through the later clear of a0, the ramp addressing wrapping around the data store, and a restart after a reset in mid-run. The bench checks them by comparing a0 after every edge against a program-level model across many loop passes.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_BR   = 7'b1100011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_BNE  = 3'b001;
  localparam logic [2:0] F3_WORD = 3'b010;

  localparam logic [4:0] REG_ZERO = 5'd0;
  localparam logic [4:0] REG_LIM  = 5'd1;
  localparam logic [4:0] REG_A0   = 5'd10;
  localparam logic [4:0] REG_PTR  = 5'd11;

  typedef struct packed {
    logic regWrite;
    logic aluSrcImm;
    logic aluSub;
    logic branch;
    logic memToReg;
    logic immIsB;
  } ctrl_t;

  function automatic logic [31:0] encI(input logic [11:0] imm, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] encB(input logic [12:0] off, input logic [4:0] rs2,
                                       input logic [4:0] rs1);
    return {off[12], off[10:5], rs2, rs1, F3_BNE, off[4:1], off[11], OP_BR};
  endfunction

  // Built-in program; word index -> instruction. Unused slots hold zero (an unsupported word).
  function automatic logic [31:0] progWord(input int idx, input int limit);
    case (idx)
      0:  return encI(12'(limit), REG_ZERO, F3_ADD, REG_LIM, OP_IMM);
      1:  return encI(12'd7, REG_ZERO, F3_ADD, REG_ZERO, OP_IMM);
      2:  return 32'h0010_8533;
      3:  return encI(12'd0, REG_ZERO, F3_ADD, REG_A0, OP_IMM);
      4:  return encI(12'd1, REG_A0, F3_ADD, REG_A0, OP_IMM);
      5:  return encB(13'(-4), REG_LIM, REG_A0);
      6:  return encI(12'd0, REG_PTR, F3_WORD, REG_A0, OP_LOAD);
      7:  return encI(12'd4, REG_PTR, F3_ADD, REG_PTR, OP_IMM);
      8:  return encI(12'd0, REG_PTR, F3_WORD, REG_A0, OP_LOAD);
      9:  return encB(13'd8, REG_ZERO, REG_ZERO);
      10: return encB(13'(-28), REG_ZERO, REG_A0);
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/mini_core_ctrl.sv
module mini_core_ctrl
  import mini_core_pkg::*;
#(
  parameter bit ENABLE_LW = 1'b1
) (
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_IMM: if (funct3 == F3_ADD) begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
      end
      OP_BR: if (funct3 == F3_BNE) begin
        ctrl.branch = 1'b1;
        ctrl.aluSub = 1'b1;
        ctrl.immIsB = 1'b1;
      end
      OP_LOAD: if (ENABLE_LW && funct3 == F3_WORD) begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mini_core_dpath.sv
module mini_core_dpath
  import mini_core_pkg::*;
#(
  parameter int IMEM_WORDS  = 16,
  parameter int DMEM_WORDS  = 16,
  parameter int LOOP_LIMIT  = 255,
  parameter int SAMPLE_BASE = 37,
  parameter int SAMPLE_STEP = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrl_t       ctrl,
  output logic [31:0] instr,
  output logic [31:0] pc,
  output logic [31:0] imm,
  output logic        aluZero,
  output logic [31:0] a0Out
);

  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);
  localparam int NREG = 32;

  logic [31:0] imemArr [IMEM_WORDS];
  logic [31:0] dmemArr [DMEM_WORDS];

  // Read-only stores filled at elaboration
  for (genvar gi = 0; gi < IMEM_WORDS; gi++) begin : g_imem
    assign imemArr[gi] = progWord(gi, LOOP_LIMIT);
  end
  for (genvar gd = 0; gd < DMEM_WORDS; gd++) begin : g_dmem
    assign dmemArr[gd] = 32'(SAMPLE_BASE + gd * SAMPLE_STEP);
  end

  // Asynchronous fetch
  assign instr = imemArr[pc[IA_W+1:2]];

  logic [4:0] rs1, rs2, rd;
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];
  assign rd  = instr[11:7];

  // Register file: two combinational reads, one clocked write
  logic [31:0] regs [NREG];
  logic [31:0] rs1Val, rs2Val, wbData;

  assign rs1Val = (rs1 == REG_ZERO) ? 32'd0 : regs[rs1];
  assign rs2Val = (rs2 == REG_ZERO) ? 32'd0 : regs[rs2];
  assign a0Out  = regs[REG_A0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctrl.regWrite && rd != REG_ZERO) begin
      regs[rd] <= wbData;
    end
  end

  // Sign extension
  logic [31:0] immI, immB;
  assign immI = {{20{instr[31]}}, instr[31:20]};
  assign immB = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm  = ctrl.immIsB ? immB : immI;

  // ALU with operand mux
  logic [31:0] srcB, aluRes, loadWord;
  assign srcB    = ctrl.aluSrcImm ? imm : rs2Val;
  assign aluRes  = ctrl.aluSub ? (rs1Val - srcB) : (rs1Val + srcB);
  assign aluZero = (aluRes == 32'd0);

  // Asynchronous data read
  assign loadWord = dmemArr[aluRes[DA_W+1:2]];
  assign wbData   = ctrl.memToReg ? loadWord : aluRes;

  // Program counter
  logic [31:0] pcNext;
  assign pcNext = (ctrl.branch && !aluZero) ? (pc + imm) : (pc + 32'd4);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/mini_core.sv
module mini_core
  import mini_core_pkg::*;
#(
  parameter int IMEM_WORDS  = 16,
  parameter int DMEM_WORDS  = 16,
  parameter int LOOP_LIMIT  = 255,
  parameter int SAMPLE_BASE = 37,
  parameter int SAMPLE_STEP = 11,
  parameter bit ENABLE_LW   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] a0Out
);

  ctrl_t       ctrl;
  logic [31:0] instr, pc, imm;
  logic        aluZero;

  mini_core_ctrl #(.ENABLE_LW(ENABLE_LW)) uCtrl (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .ctrl   (ctrl)
  );

  mini_core_dpath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .LOOP_LIMIT (LOOP_LIMIT),
    .SAMPLE_BASE(SAMPLE_BASE),
    .SAMPLE_STEP(SAMPLE_STEP)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .instr  (instr),
    .pc     (pc),
    .imm    (imm),
    .aluZero(aluZero),
    .a0Out  (a0Out)
  );

endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
  import mini_core_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input ctrl_t       ctrl,
  input logic [31:0] imm,
  input logic        aluZero,
  input logic [31:0] a0Out
);

  logic taken, known, writesA0;
  assign taken    = ctrl.branch && !aluZero;
  assign known    = (instr[6:0] == OP_IMM  && instr[14:12] == F3_ADD)
                 || (instr[6:0] == OP_BR   && instr[14:12] == F3_BNE)
                 || (instr[6:0] == OP_LOAD && instr[14:12] == F3_WORD);
  assign writesA0 = ctrl.regWrite && (instr[11:7] == REG_A0);

  a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc == $past(pc) + 32'd4);

  a_r3_branch_target: assert property (@(posedge clk) disable iff (rst)
    taken |=> pc == $past(pc) + $past(imm));

  a_r3_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  a_r6_unknown_idle: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!ctrl.regWrite && !ctrl.branch));

  a_r8_a0_hold: assert property (@(posedge clk) disable iff (rst)
    !writesA0 |=> $stable(a0Out));

  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (pc == 32'd0 && a0Out == 32'd0));

endmodule

bind mini_core mini_core_chk uChk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc),
  .instr  (instr),
  .ctrl   (ctrl),
  .imm    (imm),
  .aluZero(aluZero),
  .a0Out  (a0Out)
);

// File: tb/tb_mini_core.sv
`timescale 1ns/1ps
module tb_mini_core;

  localparam int LIMIT = 5;
  localparam int BASE  = 37;
  localparam int STEP  = 11;
  localparam int DW    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a0Out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  mini_core #(
    .DMEM_WORDS (DW),
    .LOOP_LIMIT (LIMIT),
    .SAMPLE_BASE(BASE),
    .SAMPLE_STEP(STEP)
  ) dut (
    .clk  (clk),
    .rst  (rst),
    .a0Out(a0Out)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a0Out actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sample(input int i);
    return BASE + (i % DW) * STEP;
  endfunction

  // Program-level model: after each edge, compare a0 with the value the program implies
  task automatic runProgram(input int steps);
    int    idx = 0;
    int    a   = 0;
    int    p   = 0;
    string tag;
    for (int s = 0; s < steps; s++) begin
      @(posedge clk);
      @(negedge clk);
      case (idx)
        0:  begin tag = "R1"; idx = 1; end
        1:  begin tag = "R5"; idx = 2; end
        2:  begin tag = "R6"; idx = 3; end
        3:  begin a = 0; tag = "R5"; idx = 4; end
        4:  begin a = a + 1; tag = "R2"; idx = 5; end
        5:  begin tag = "R3"; idx = (a != LIMIT) ? 4 : 6; end
        6:  begin a = sample(p); tag = "R4"; idx = 7; end
        7:  begin tag = "R8"; idx = 8; end
        8:  begin a = sample(p + 1); tag = "R4"; idx = 9; end
        9:  begin tag = "R3"; idx = 10; end
        default: begin tag = "R9"; idx = 3; p = p + 1; end
      endcase
      check(tag, a0Out, 32'(a));
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", a0Out, 32'd0);
    rst = 1'b0;
    runProgram(420);
    // Mid-run reset: a0 must clear and the program restart from pass 0
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7", a0Out, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R7", a0Out, 32'd0);
    rst = 1'b0;
    runProgram(80);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule